// File: doc/BRIEF.md
# Translation Cache with Pinned Entry Region

This block is a small address-translation cache with two storage regions. One is a fully associative pinned region whose entries survive a bulk flush. The other is a direct-mapped main region. Completed page-table-walk results arrive on a fill port, each carrying a virtual page, an address-space identifier (ASID), a physical page and a global flag. A 32-bit control register decides where each fill goes. While its keep bit is set, fills go into the pinned region at the slot named by a rotating slot pointer, and that pointer advances after each such fill. While the keep bit is clear, fills go into the main region.

Software pins a translation with four steps. It sets the keep bit, lets one walk fill land, reads the register back to see the advanced pointer, and then clears the keep bit again. Three maintenance commands remove entries: a flush of the main region only, a removal by virtual page, and a removal by ASID. A combinational lookup port returns a hit flag, the physical page, and a flag telling which region supplied the hit.

Top module: `tlb_lock_ctrl`

## Requirements
- R1: After reset the control register reads 0 and no lookup hits.
- R2: The control register holds the keep bit at bit 0 and the 3-bit slot pointer at bits [28:26]. Every other bit reads 0. A write loads both fields from the written word.
- R3: A fill while the keep bit is 1 writes the pinned slot named by the pointer. The pointer then increases by one and wraps from 7 to 0.
- R4: A fill while the keep bit is 0 writes main-region entry vpn[3:0] and replaces whatever that entry held. The register value is left unchanged.
- R5: When a register write and a pinned fill fall in the same cycle, the fill is stored at the old pointer, and the register takes the written value with no increment.
- R6: A lookup hits when a valid entry has an equal virtual page and either has its global flag set or has an ASID equal to the lookup ASID. On a hit, lk_ppn is that entry's physical page and lk_locked is 1 when the entry is pinned. On a miss, lk_ppn is 0.
- R7: When both regions hit, the pinned entry supplies the result.
- R8: Command code 1 invalidates every main-region entry and leaves every pinned entry valid.
- R9: Command code 2 invalidates every entry in either region whose virtual page equals maint_vpn, regardless of its ASID or global flag.
- R10: Command code 3 invalidates every non-global entry in either region whose ASID equals maint_asid. Global entries stay valid.
- R11: A maintenance command applied at one clock edge is visible to a lookup in the next cycle. Code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 32 | Control register write value |
| reg_rd_data | output | 32 | Control register read value |
| fill_valid | input | 1 | Walk result present this cycle |
| fill_vpn | input | 20 | Fill virtual page |
| fill_asid | input | 8 | Fill ASID |
| fill_ppn | input | 20 | Fill physical page |
| fill_global | input | 1 | Fill global flag |
| maint_cmd | input | 2 | 0 none, 1 flush main, 2 by page, 3 by ASID |
| maint_vpn | input | 20 | Page operand for code 2 |
| maint_asid | input | 8 | ASID operand for code 3 |
| lk_vpn | input | 20 | Lookup virtual page |
| lk_asid | input | 8 | Current ASID for lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Translated physical page |
| lk_locked | output | 1 | Hit came from the pinned region |

## Verification
Two situations are hard to reach from the ports. The first is a register write that lands in the same cycle as a pinned fill. The second is a pointer that has wrapped over pinned slots that are still live. The bench performs ten pinned fills in a row, so that the pointer wraps and overwrites slots 0 and 1. It then raises a register write and a fill on the same edge. It also pins a page that already sits in the main region, which makes both regions hit at once. After every fill phase and every maintenance command, the bench sweeps each known page against four ASIDs and compares the result with a reference model that it keeps from the requirements.

// File: rtl/tlb_lock_pkg.sv
// Shared constants and the maintenance command encoding.
package tlb_lock_pkg;
    localparam int REG_W       = 32;
    localparam int KEEP_BIT    = 0;
    localparam int SLOT_LSB    = 26;

    typedef enum logic [1:0] {
        MNT_NONE          = 2'd0,
        MNT_FLUSH_MAIN    = 2'd1,
        MNT_BY_PAGE       = 2'd2,
        MNT_BY_ASID       = 2'd3
    } mnt_cmd_e;
endpackage

// File: rtl/tlb_lock_reg.sv
// Control register: holds the keep bit and the rotating pinned-slot pointer.
// Assumes SLOT_W <= 6 so that the pointer field fits below bit 32.
module tlb_lock_reg
    import tlb_lock_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              fill_valid,
    output logic [REG_W-1:0]  rd_data,
    output logic              keep,
    output logic [SLOT_W-1:0] slot
);
    // Update fields: a software write wins, otherwise a pinned fill advances the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep <= 1'b0;
            slot <= '0;
        end else if (wr_en) begin
            keep <= wr_data[KEEP_BIT];
            slot <= wr_data[SLOT_LSB +: SLOT_W];
        end else if (fill_valid && keep) begin
            slot <= slot + SLOT_W'(1);
        end
    end

    // Assemble the read word with all unused bits at zero.
    always_comb begin
        rd_data                     = '0;
        rd_data[KEEP_BIT]           = keep;
        rd_data[SLOT_LSB +: SLOT_W] = slot;
    end
endmodule

// File: rtl/tlb_entry_array.sv
// Array of translation entries with write-by-index, maintenance invalidation
// and lookup. FLUSH_IMMUNE keeps entries through the main-flush command.
// DIRECT_MAPPED selects indexed lookup (index = low page bits); otherwise a
// full associative scan with the lowest matching index taking precedence.
// Assumes N is a power of two.
module tlb_entry_array
    import tlb_lock_pkg::*;
#(
    parameter int N             = 8,
    parameter int VPN_W         = 20,
    parameter int PPN_W         = 20,
    parameter int ASID_W        = 8,
    parameter bit FLUSH_IMMUNE  = 1'b0,
    parameter bit DIRECT_MAPPED = 1'b0,
    localparam int IDX_W        = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              wr_glb,
    input  mnt_cmd_e          mnt_cmd,
    input  logic [VPN_W-1:0]  mnt_vpn,
    input  logic [ASID_W-1:0] mnt_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn
);
    logic              e_v    [N];
    logic              e_g    [N];
    logic [VPN_W-1:0]  e_vpn  [N];
    logic [ASID_W-1:0] e_asid [N];
    logic [PPN_W-1:0]  e_ppn  [N];
    logic [N-1:0]      kill;
    logic [N-1:0]      match;

    // Per-entry invalidation and lookup match terms.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            kill[i]  = ((mnt_cmd == MNT_FLUSH_MAIN) && !FLUSH_IMMUNE)
                    || ((mnt_cmd == MNT_BY_PAGE) && (e_vpn[i] == mnt_vpn))
                    || ((mnt_cmd == MNT_BY_ASID) && !e_g[i] && (e_asid[i] == mnt_asid));
            match[i] = e_v[i] && (e_vpn[i] == lk_vpn) && (e_g[i] || (e_asid[i] == lk_asid));
        end
    end

    // Entry storage: a fill to an entry overrides a same-cycle invalidation of it.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                e_v[i]    <= 1'b0;
                e_g[i]    <= 1'b0;
                e_vpn[i]  <= '0;
                e_asid[i] <= '0;
                e_ppn[i]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                e_v[i]    <= 1'b1;
                e_g[i]    <= wr_glb;
                e_vpn[i]  <= wr_vpn;
                e_asid[i] <= wr_asid;
                e_ppn[i]  <= wr_ppn;
            end else if (kill[i]) begin
                e_v[i]    <= 1'b0;
            end
        end
    end

    generate
        if (DIRECT_MAPPED) begin : g_indexed
            logic [IDX_W-1:0] idx;
            // Indexed lookup: only the entry selected by the low page bits can hit.
            always_comb begin
                idx    = lk_vpn[IDX_W-1:0];
                lk_hit = match[idx];
                lk_ppn = match[idx] ? e_ppn[idx] : '0;
            end
        end else begin : g_assoc
            // Associative lookup: scan downward so the lowest matching slot wins.
            always_comb begin
                lk_hit = 1'b0;
                lk_ppn = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (match[i]) begin
                        lk_hit = 1'b1;
                        lk_ppn = e_ppn[i];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tlb_lock_ctrl.sv
// Translation cache top: control register, pinned associative region and
// direct-mapped main region. Fills are steered by the keep bit; lookup gives
// the pinned region precedence. Lookup is combinational.
module tlb_lock_ctrl
    import tlb_lock_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int PPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int LOCK_N = 8,
    parameter int MAIN_N = 16,
    localparam int SLOT_W = $clog2(LOCK_N),
    localparam int MIDX_W = $clog2(MAIN_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wr_data,
    output logic [31:0]       reg_rd_data,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_global,
    input  logic [1:0]        maint_cmd,
    input  logic [VPN_W-1:0]  maint_vpn,
    input  logic [ASID_W-1:0] maint_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              lk_locked
);
    logic              keep;
    logic [SLOT_W-1:0] slot;
    logic              pin_hit, main_hit;
    logic [PPN_W-1:0]  pin_ppn, main_ppn;
    mnt_cmd_e          cmd;

    assign cmd = mnt_cmd_e'(maint_cmd);

    tlb_lock_reg #(.SLOT_W(SLOT_W)) i_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
        .fill_valid(fill_valid), .rd_data(reg_rd_data), .keep(keep), .slot(slot)
    );

    tlb_entry_array #(
        .N(LOCK_N), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W),
        .FLUSH_IMMUNE(1'b1), .DIRECT_MAPPED(1'b0)
    ) i_pinned (
        .clk(clk), .rst_n(rst_n), .wr_en(fill_valid && keep), .wr_idx(slot),
        .wr_vpn(fill_vpn), .wr_asid(fill_asid), .wr_ppn(fill_ppn), .wr_glb(fill_global),
        .mnt_cmd(cmd), .mnt_vpn(maint_vpn), .mnt_asid(maint_asid),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(pin_hit), .lk_ppn(pin_ppn)
    );

    tlb_entry_array #(
        .N(MAIN_N), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W),
        .FLUSH_IMMUNE(1'b0), .DIRECT_MAPPED(1'b1)
    ) i_main (
        .clk(clk), .rst_n(rst_n), .wr_en(fill_valid && !keep),
        .wr_idx(fill_vpn[MIDX_W-1:0]),
        .wr_vpn(fill_vpn), .wr_asid(fill_asid), .wr_ppn(fill_ppn), .wr_glb(fill_global),
        .mnt_cmd(cmd), .mnt_vpn(maint_vpn), .mnt_asid(maint_asid),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(main_hit), .lk_ppn(main_ppn)
    );

    // Merge region results with the pinned region taking precedence.
    always_comb begin
        lk_hit    = pin_hit || main_hit;
        lk_locked = pin_hit;
        lk_ppn    = pin_hit ? pin_ppn : main_ppn;
    end
endmodule

// File: rtl/tlb_lock_ctrl_chk.sv
// Property checker for tlb_lock_ctrl, observing ports only; bound below.
module tlb_lock_ctrl_chk #(
    parameter int VPN_W  = 20,
    parameter int PPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int LOCK_N = 8,
    localparam int SLOT_W = $clog2(LOCK_N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [31:0]       reg_wr_data,
    input logic [31:0]       reg_rd_data,
    input logic              fill_valid,
    input logic [1:0]        maint_cmd,
    input logic [VPN_W-1:0]  maint_vpn,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic              lk_hit,
    input logic              lk_locked
);
    localparam logic [31:0] USED = 32'h1 | (32'((1 << SLOT_W) - 1) << 26);

    p_unused_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data & ~USED) == 32'h0);

    p_write_loads_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> reg_rd_data == ($past(reg_wr_data) & USED));

    p_pinned_fill_advances_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && reg_rd_data[0] && !reg_wr_en)
        |=> reg_rd_data[26 +: SLOT_W] == $past(reg_rd_data[26 +: SLOT_W]) + SLOT_W'(1));

    p_main_fill_keeps_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !reg_rd_data[0] && !reg_wr_en) |=> $stable(reg_rd_data));

    p_flush_leaves_pinned_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (maint_cmd == 2'd1 && !fill_valid) |=> (!lk_hit || lk_locked));

    p_page_inv_no_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (maint_cmd == 2'd2 && !fill_valid) |=> !(lk_hit && lk_vpn == $past(maint_vpn)));
endmodule

bind tlb_lock_ctrl tlb_lock_ctrl_chk #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W), .LOCK_N(LOCK_N)
) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .fill_valid(fill_valid), .maint_cmd(maint_cmd),
    .maint_vpn(maint_vpn), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_locked(lk_locked)
);

// File: tb/test_tlb_lock_ctrl.sv
// Self-checking bench: reference model kept from the requirements, with
// lookup sweeps over every known page and four ASIDs after each phase.
module test_tlb_lock_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data, reg_rd_data;
    logic        fill_valid, fill_global;
    logic [19:0] fill_vpn, fill_ppn, maint_vpn, lk_vpn, lk_ppn;
    logic [7:0]  fill_asid, maint_asid, lk_asid;
    logic [1:0]  maint_cmd;
    logic        lk_hit, lk_locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model.
    bit          pv [8];  bit pg [8];  logic [19:0] pvpn [8];  logic [7:0] pasid [8];  logic [19:0] pppn [8];
    bit          mv [16]; bit mg [16]; logic [19:0] mvpn [16]; logic [7:0] masid [16]; logic [19:0] mppn [16];
    logic [2:0]  m_slot;
    bit          m_keep;

    always #2 clk = ~clk;

    tlb_lock_ctrl i_tlb_lock_ctrl (.*);

    task automatic step();
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] reg_word(logic [2:0] s, bit k);
        return {3'b000, s, 25'd0, k};
    endfunction

    task automatic check_reg(string tag);
        checks++;
        if (reg_rd_data !== reg_word(m_slot, m_keep)) begin
            fails++;
            $display("FAIL %s reg actual=%h expected=%h", tag, reg_rd_data, reg_word(m_slot, m_keep));
        end
    endtask

    task automatic check_lookup(logic [19:0] v, logic [7:0] a, string tag);
        bit e_hit = 0; bit e_lock = 0; logic [19:0] e_ppn = '0;
        logic [3:0] ix = v[3:0];
        if (mv[ix] && mvpn[ix] == v && (mg[ix] || masid[ix] == a)) begin
            e_hit = 1; e_ppn = mppn[ix];
        end
        for (int i = 7; i >= 0; i--)
            if (pv[i] && pvpn[i] == v && (pg[i] || pasid[i] == a)) begin
                e_hit = 1; e_lock = 1; e_ppn = pppn[i];
            end
        lk_vpn = v; lk_asid = a;
        #0.5;
        checks++;
        if (lk_hit !== e_hit || lk_ppn !== e_ppn || lk_locked !== e_lock) begin
            fails++;
            $display("FAIL %s lookup vpn=%h asid=%0d actual hit=%b ppn=%h locked=%b expected hit=%b ppn=%h locked=%b",
                     tag, v, a, lk_hit, lk_ppn, lk_locked, e_hit, e_ppn, e_lock);
        end
    endtask

    task automatic sweep(string tag);
        for (int a = 0; a < 4; a++) begin
            for (int i = 0; i < 16; i++) check_lookup(20'h100 + 20'(i), 8'(a), tag);
            for (int k = 0; k < 10; k++) check_lookup(20'h300 + 20'(k), 8'(a), tag);
            check_lookup(20'h210, 8'(a), tag);
            check_lookup(20'h400, 8'(a), tag);
        end
    endtask

    task automatic fill(logic [19:0] v, logic [7:0] a, logic [19:0] p, bit g, bit with_wr, logic [31:0] wv);
        fill_valid = 1; fill_vpn = v; fill_asid = a; fill_ppn = p; fill_global = g;
        reg_wr_en = with_wr; reg_wr_data = wv;
        step();
        fill_valid = 0; reg_wr_en = 0;
        if (m_keep) begin
            pv[m_slot] = 1; pg[m_slot] = g; pvpn[m_slot] = v; pasid[m_slot] = a; pppn[m_slot] = p;
            if (!with_wr) m_slot = m_slot + 3'd1;
        end else begin
            mv[v[3:0]] = 1; mg[v[3:0]] = g; mvpn[v[3:0]] = v; masid[v[3:0]] = a; mppn[v[3:0]] = p;
        end
        if (with_wr) begin m_keep = wv[0]; m_slot = wv[28:26]; end
    endtask

    task automatic write_reg(logic [31:0] wv);
        reg_wr_en = 1; reg_wr_data = wv;
        step();
        reg_wr_en = 0;
        m_keep = wv[0]; m_slot = wv[28:26];
    endtask

    task automatic maint(logic [1:0] c, logic [19:0] v, logic [7:0] a);
        maint_cmd = c; maint_vpn = v; maint_asid = a;
        step();
        maint_cmd = 0;
        for (int i = 0; i < 8; i++)
            if ((c == 2 && pvpn[i] == v) || (c == 3 && !pg[i] && pasid[i] == a)) pv[i] = 0;
        for (int i = 0; i < 16; i++)
            if (c == 1 || (c == 2 && mvpn[i] == v) || (c == 3 && !mg[i] && masid[i] == a)) mv[i] = 0;
    endtask

    task automatic main_fills();
        for (int i = 0; i < 16; i++)
            fill(20'h100 + 20'(i), 8'(i % 4), 20'h500 + 20'(i), i == 5, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++)  begin pv[i] = 0; pg[i] = 0; pvpn[i] = '1; pasid[i] = 0; pppn[i] = 0; end
        for (int i = 0; i < 16; i++) begin mv[i] = 0; mg[i] = 0; mvpn[i] = '1; masid[i] = 0; mppn[i] = 0; end
        m_slot = 0; m_keep = 0;
        rst_n = 0; reg_wr_en = 0; reg_wr_data = 0; fill_valid = 0; fill_vpn = 0; fill_asid = 0;
        fill_ppn = 0; fill_global = 0; maint_cmd = 0; maint_vpn = 0; maint_asid = 0; lk_vpn = 0; lk_asid = 0;
        #1;
        repeat (3) step();
        rst_n = 1;
        step();
        check_reg("R1");
        sweep("R1");

        // R2: unused bits read zero, both fields load from the written word.
        write_reg(32'hFFFF_FFFF); check_reg("R2");
        write_reg(32'h0000_0000); check_reg("R2");
        write_reg(32'h1400_0000); check_reg("R2");
        write_reg(32'h0000_0000); check_reg("R2");

        // R4/R6: main-region fills keep the register; lookups use page, ASID and global.
        main_fills();
        check_reg("R4");
        sweep("R6");
        fill(20'h210, 8'd0, 20'h5AA, 0, 0, 0);
        check_reg("R4");
        sweep("R4");

        // R3: ten pinned fills wrap the pointer over slots 0 and 1.
        write_reg(32'h0000_0001);
        for (int k = 0; k < 10; k++) begin
            fill(20'h300 + 20'(k), 8'd2, 20'h700 + 20'(k), k == 4, 0, 0);
            check_reg("R3");
        end
        sweep("R3");

        // R7: pin a page that also sits in the main region.
        fill(20'h105, 8'd0, 20'h9AA, 0, 0, 0);
        check_reg("R3");
        sweep("R7");

        // R5: a register write on the same edge as a pinned fill.
        fill(20'h400, 8'd2, 20'hABC, 0, 1, 32'h1800_0001);
        check_reg("R5");
        sweep("R5");
        write_reg(32'h1800_0000);
        check_reg("R2");

        // R11: code 0 leaves every entry in place.
        maint(2'd0, 20'h105, 8'd2);
        sweep("R11");

        // R8: flush the main region; pinned entries stay.
        maint(2'd1, 0, 0);
        sweep("R8");

        // R9: remove one page from both regions.
        main_fills();
        maint(2'd2, 20'h105, 8'd0);
        sweep("R9");

        // R10: remove non-global entries of ASID 2 in both regions.
        maint(2'd3, 0, 8'd2);
        sweep("R10");
        check_reg("R10");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule